// File: doc/BRIEF.md
# External Data Region Decoder

This block sits between the core's external data-move path and the bus sequencer. For each accepted request it takes a 24-bit address, an access-type code and two static wait-state configuration bits. It returns a translated physical address, a flag telling whether the target is on-chip or external, and a stall/acknowledge handshake. The stall is held for one bus state when a wait state applies. The upper byte of the address names a 64 KiB region. Region 01h takes its wait-state choice from the second configuration bit, and every other region takes it from the first. This holds for all four forms of the data move, whether the pointer is 16 bits or an 8-bit register, and whether the move is a read or a write.

An active-low alias enable makes reads in the window 00:E000h–00:FFFFh land in on-chip code memory at FF:2000h–FF:3FFFh. The low 13 bits pass through unchanged. Writes are never aliased. Addresses in FF:0000h–FF:3FFFh are on-chip and never take a wait state.

The sequencer follows a small machine with three states:
- `S_IDLE` waits for `req_valid`.
- Accept with a wait state: `S_IDLE`→`S_WAIT`. Accept without one: `S_IDLE`→`S_GRANT`.
- `S_WAIT`→`S_GRANT` always.
- `S_GRANT`→`S_IDLE` always.

Top module: `xmd_region_dec`

## Requirements
- R1: During and directly after reset, `stall`, `ack`, `on_chip` and `phys_addr` are all zero.
- R2: An external access to region 01h (addr[23:16]==8'h01) takes one wait state exactly when `ws_hi` is 1. This holds for all four `acc_kind` codes: 2'b00 pointer read, 2'b01 pointer write, 2'b10 register read and 2'b11 register write. `acc_kind[0]`=1 means write.
- R3: An external access to any region other than 01h takes one wait state exactly when `ws_lo` is 1.
- R4: Let the request be accepted at clock edge k. With a wait state, `stall` is high for exactly the one cycle after edge k and `ack` is high for the next cycle. Without a wait state, `ack` is high for the cycle after edge k and `stall` stays low. `ack` is a one-cycle pulse.
- R5: With `remap_n`=0, a read of 00:E000h+n (n<2000h) yields `phys_addr` FF:2000h+n with `on_chip`=1 and no wait state. 00:DFFFh is not aliased.
- R6: With `remap_n`=1, addresses in 00:E000h–00:FFFFh pass unchanged and are external.
- R7: Writes (`acc_kind[0]`=1) inside the alias window are never aliased.
- R8: A physical address in FF:0000h–FF:3FFFh gives `on_chip`=1 and never stalls. Every other address gives `on_chip`=0.
- R9: A `req_valid` seen while an access is in progress is ignored and produces no extra `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe, taken only when idle |
| addr | input | 24 | Logical address, region in [23:16] |
| acc_kind | input | 2 | Access code: bit0 write, bit1 register form |
| ws_lo | input | 1 | Wait-state bit for regions other than 01h |
| ws_hi | input | 1 | Wait-state bit for region 01h |
| remap_n | input | 1 | Active-low alias window enable |
| phys_addr | output | 24 | Translated address, valid from the cycle after accept |
| on_chip | output | 1 | Target is on-chip code memory |
| stall | output | 1 | Wait-state request to the bus sequencer |
| ack | output | 1 | Access complete, one-cycle pulse |

## Verification
`phys_addr` and `on_chip` become valid one cycle after the accepting edge and stay valid through `ack`. `ack` comes one cycle after accept when there is no wait state, and two cycles after accept with one. The monitor samples on falling edges, counts the `stall` cycles seen since the previous `ack`, and checks address, flag and stall count when `ack` appears. This gives each result one fixed sampling point relative to the accepting edge. An `ack` that arrives with nothing in the queue is reported, and this is how ignored requests are checked.

// File: rtl/xmd_pkg.sv
package xmd_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_GRANT
    } xmd_state_e;

    localparam int ADDR_W   = 24;
    localparam int REGION_W = 8;
    localparam int OFFS_W   = ADDR_W - REGION_W;
endpackage

// File: rtl/xmd_translate.sv
module xmd_translate
    import xmd_pkg::*;
#(
    parameter bit                ALIAS_EN      = 1'b1,
    parameter logic [REGION_W-1:0] ALIAS_REGION  = 8'h00,
    parameter logic [OFFS_W-1:0]   ALIAS_BASE    = 16'hE000,
    parameter logic [REGION_W-1:0] TARGET_REGION = 8'hFF,
    parameter logic [OFFS_W-1:0]   TARGET_BASE   = 16'h2000,
    parameter int                  WINDOW_BITS   = 13,
    parameter logic [OFFS_W-1:0]   ONCHIP_LIMIT  = 16'h4000
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              is_write,
    input  logic              remap_n,
    output logic [ADDR_W-1:0] addr_out,
    output logic              on_chip
);
    localparam int HI_W = OFFS_W - WINDOW_BITS;

    logic in_window;
    logic alias_hit;

    assign in_window = (addr_in[ADDR_W-1:OFFS_W] == ALIAS_REGION) &&
                       (addr_in[OFFS_W-1:WINDOW_BITS] == ALIAS_BASE[OFFS_W-1:WINDOW_BITS]);

    generate
        if (ALIAS_EN) begin : g_alias
            assign alias_hit = in_window && !remap_n && !is_write;
        end else begin : g_no_alias
            assign alias_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        if (alias_hit) begin
            addr_out = {TARGET_REGION,
                        TARGET_BASE[OFFS_W-1:WINDOW_BITS],
                        addr_in[WINDOW_BITS-1:0]};
        end else begin
            addr_out = addr_in;
        end
    end

    assign on_chip = (addr_out[ADDR_W-1:OFFS_W] == TARGET_REGION) &&
                     (addr_out[OFFS_W-1:0] < ONCHIP_LIMIT);

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = TARGET_BASE[OFFS_W-1:WINDOW_BITS];
endmodule

// File: rtl/xmd_wait_sel.sv
module xmd_wait_sel
    import xmd_pkg::*;
#(
    parameter logic [REGION_W-1:0] HI_REGION = 8'h01
) (
    input  logic [REGION_W-1:0] region,
    input  logic                target_on_chip,
    input  logic                ws_lo,
    input  logic                ws_hi,
    output logic                need_wait
);
    logic ws_bit;

    assign ws_bit    = (region == HI_REGION) ? ws_hi : ws_lo;
    assign need_wait = ws_bit && !target_on_chip;
endmodule

// File: rtl/xmd_region_dec.sv
module xmd_region_dec
    import xmd_pkg::*;
#(
    parameter bit ALIAS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_kind,
    input  logic              ws_lo,
    input  logic              ws_hi,
    input  logic              remap_n,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              on_chip,
    output logic              stall,
    output logic              ack
);
    xmd_state_e        state_q;
    xmd_state_e        state_d;
    logic              is_write;
    logic [ADDR_W-1:0] xlat_addr;
    logic              xlat_on_chip;
    logic              need_wait;
    logic              busy;
    logic              accept;

    always_comb begin
        unique case (acc_kind)
            2'b00, 2'b10: is_write = 1'b0;
            2'b01, 2'b11: is_write = 1'b1;
            default:      is_write = 1'b0;
        endcase
    end

    xmd_translate #(
        .ALIAS_EN (ALIAS_EN)
    ) u_translate (
        .addr_in  (addr),
        .is_write (is_write),
        .remap_n  (remap_n),
        .addr_out (xlat_addr),
        .on_chip  (xlat_on_chip)
    );

    xmd_wait_sel u_wait_sel (
        .region         (addr[ADDR_W-1:OFFS_W]),
        .target_on_chip (xlat_on_chip),
        .ws_lo          (ws_lo),
        .ws_hi          (ws_hi),
        .need_wait      (need_wait)
    );

    assign busy   = (state_q != S_IDLE);
    assign accept = req_valid && !busy;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = need_wait ? S_WAIT : S_GRANT;
            S_WAIT:  state_d = S_GRANT;
            S_GRANT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phys_addr <= '0;
            on_chip   <= 1'b0;
        end else if (accept) begin
            phys_addr <= xlat_addr;
            on_chip   <= xlat_on_chip;
        end
    end

    always_comb begin
        stall = 1'b0;
        ack   = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_WAIT:  stall = 1'b1;
            S_GRANT: ack   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/xmd_checker.sv
module xmd_checker
    import xmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        acc_kind,
    input logic              ws_lo,
    input logic              ws_hi,
    input logic              remap_n,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              on_chip,
    input logic              stall,
    input logic              ack
);
    logic take;
    logic win;
    assign take = req_valid && !busy;
    assign win  = (addr[23:13] == 11'b0000_0000_111);

    p_stall_then_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!stall && ack));

    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stall, ack}));

    p_hi_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && addr[23:16] == 8'h01) |=> (stall == $past(ws_hi)));

    p_lo_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && addr[23:16] != 8'h01 && addr[23:16] != 8'hFF && !win)
        |=> (stall == $past(ws_lo)));

    p_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win && !remap_n && !acc_kind[0])
        |=> (on_chip && !stall && phys_addr == {11'b1111_1111_001, $past(addr[12:0])}));

    p_no_alias_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win && acc_kind[0]) |=> (phys_addr == $past(addr) && !on_chip));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy && !ack) |=> $stable(phys_addr));
endmodule

bind xmd_region_dec xmd_checker u_xmd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .addr      (addr),
    .acc_kind  (acc_kind),
    .ws_lo     (ws_lo),
    .ws_hi     (ws_hi),
    .remap_n   (remap_n),
    .phys_addr (phys_addr),
    .on_chip   (on_chip),
    .stall     (stall),
    .ack       (ack)
);

// File: tb/test_xmd_region_dec.sv
module test_xmd_region_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        ws_lo = 1'b0;
    logic        ws_hi = 1'b0;
    logic        remap_n = 1'b1;
    logic [23:0] phys_addr;
    logic        on_chip;
    logic        stall;
    logic        ack;

    int checks = 0;
    int fails  = 0;
    int acks_seen = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [23:0] phys;
        logic        oc;
        int          nstall;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    xmd_region_dec i_xmd_region_dec (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr(addr),
        .acc_kind(acc_kind), .ws_lo(ws_lo), .ws_hi(ws_hi), .remap_n(remap_n),
        .phys_addr(phys_addr), .on_chip(on_chip), .stall(stall), .ack(ack)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Model written from the requirement text
    function automatic exp_t model(input logic [23:0] a, input logic [1:0] k,
                                   input logic lo, input logic hi, input logic rn,
                                   input string tag);
        exp_t e;
        logic win, alias_on, ws;
        win      = (a[23:16] == 8'h00) && (a[15:13] == 3'b111);
        alias_on = win && !rn && !k[0];
        e.phys   = alias_on ? {8'hFF, 3'b001, a[12:0]} : a;
        e.oc     = (e.phys[23:16] == 8'hFF) && (e.phys[15:0] < 16'h4000);
        ws       = (a[23:16] == 8'h01) ? hi : lo;
        e.nstall = (ws && !e.oc) ? 1 : 0;
        e.tag    = tag;
        return e;
    endfunction

    task automatic access(input logic [23:0] a, input logic [1:0] k,
                          input logic lo, input logic hi, input logic rn,
                          input string tag, input int hold = 1);
        @(negedge clk);
        addr = a; acc_kind = k; ws_lo = lo; ws_hi = hi; remap_n = rn;
        exp_q.push_back(model(a, k, lo, hi, rn, tag));
        req_valid = 1'b1;
        repeat (hold) @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: counts stall cycles, compares on ack
    int stall_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall) stall_cnt++;
            if (ack) begin
                acks_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected ack", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(phys_addr == e.phys, e.tag, "phys_addr", {8'h0, phys_addr}, {8'h0, e.phys});
                    check(on_chip == e.oc, e.tag, "on_chip", {31'h0, on_chip}, {31'h0, e.oc});
                    check(stall_cnt == e.nstall, e.tag, "stall cycles", stall_cnt, e.nstall);
                end
                stall_cnt = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "watchdog expired", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!stall && !ack && !on_chip && phys_addr == '0, "R1", "reset outputs",
              {stall, ack, on_chip, 5'b0, phys_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!stall && !ack && !on_chip && phys_addr == '0, "R1", "after reset",
              {stall, ack, on_chip, 5'b0, phys_addr}, 0);

        // R2: region 01 uses ws_hi for all four kinds
        for (int k = 0; k < 4; k++) begin
            access(24'h01_1234, 2'(k), 1'b0, 1'b1, 1'b1, "R2");
            access(24'h01_FFFF, 2'(k), 1'b1, 1'b0, 1'b1, "R2");
        end
        // R3: other regions use ws_lo
        access(24'h02_0000, 2'b00, 1'b1, 1'b0, 1'b1, "R3");
        access(24'h00_1000, 2'b11, 1'b1, 1'b0, 1'b1, "R3");
        access(24'hFE_FFFF, 2'b10, 1'b0, 1'b1, 1'b1, "R3");
        access(24'h00_FFFF, 2'b01, 1'b0, 1'b1, 1'b1, "R3");
        // R4: timing with and without wait
        access(24'h05_0000, 2'b00, 1'b1, 1'b1, 1'b1, "R4");
        access(24'h05_0000, 2'b00, 1'b0, 1'b0, 1'b1, "R4");
        // R5: alias reads
        access(24'h00_E000, 2'b00, 1'b1, 1'b1, 1'b0, "R5");
        access(24'h00_FFFF, 2'b10, 1'b1, 1'b1, 1'b0, "R5");
        access(24'h00_E123, 2'b00, 1'b1, 1'b1, 1'b0, "R5");
        access(24'h00_DFFF, 2'b00, 1'b1, 1'b1, 1'b0, "R5");
        // R6: alias disabled
        access(24'h00_E005, 2'b00, 1'b1, 1'b0, 1'b1, "R6");
        access(24'h00_F000, 2'b10, 1'b0, 1'b1, 1'b1, "R6");
        // R7: writes never aliased
        access(24'h00_E010, 2'b01, 1'b1, 1'b0, 1'b0, "R7");
        access(24'h00_FFF0, 2'b11, 1'b0, 1'b0, 1'b0, "R7");
        // R8: on-chip range
        access(24'hFF_0000, 2'b00, 1'b1, 1'b1, 1'b1, "R8");
        access(24'hFF_3FFF, 2'b01, 1'b1, 1'b1, 1'b1, "R8");
        access(24'hFF_4000, 2'b00, 1'b1, 1'b1, 1'b1, "R8");
        // R9: request held during an access is ignored
        acks_seen = 0;
        access(24'h03_0100, 2'b00, 1'b1, 1'b0, 1'b1, "R9", 2);
        repeat (4) @(negedge clk);
        check(acks_seen == 1, "R9", "ack count", acks_seen, 1);
        access(24'h03_0200, 2'b00, 1'b0, 1'b0, 1'b1, "R9", 2);
        repeat (4) @(negedge clk);
        check(acks_seen == 2, "R9", "ack count", acks_seen, 2);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule